// File: doc/BRIEF.md
# Single-Wire Pulse-Width Step Controller

This block turns one control wire into a 6-bit reference code for a DAC and an enable flag for the regulator it serves. While the wire is held high the regulator runs. Each low excursion is timed in whole microseconds, counted from a parameterised number of system clocks. The width of the excursion decides what happens:

- A short dip raises the code by one.
- A dip of medium length lowers it by one.
- A very long low period shuts the regulator down.

Widths outside these windows change nothing and produce a one-cycle error strobe.

When the wire goes high during shutdown, the block enables at once and loads the mid-scale code. It therefore comes back to mid-scale every time it is enabled. Steps saturate at both ends of the code range. A dip is rejected if the high time before it was too short.

Top module: `swstep_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters shutdown with `drv_en` = 0, `step_code` = 31 (mid-scale, the all-ones value of the lower five bits) and `pulse_err` = 0.
- R2: In shutdown, `ctrl_line` going high sets `drv_en` to 1 within five clocks, with `step_code` = 31.
- R3: A low pulse measuring 1 to 60 µs inclusive, followed by a return high, raises `step_code` by one and gives no error strobe.
- R4: A low pulse measuring 140 to 240 µs inclusive, followed by a return high, lowers `step_code` by one and gives no error strobe.
- R5: A low pulse measuring under 1 µs, 61 to 139 µs or 241 to 559 µs leaves `step_code` and `drv_en` unchanged and pulses `pulse_err` high for exactly one clock.
- R6: Steps saturate: an increment at 63 leaves 63, a decrement at 0 leaves 0, and neither case gives an error strobe.
- R7: Once the line has been low for 560 µs, `drv_en` drops while the line is still low and `step_code` returns to 31. The return high that ends that low period causes no step and no error strobe.
- R8: A low pulse that starts after less than 1 µs of high time is rejected as in R5, whatever its width.
- R9: Re-enabling after a shutdown gives `step_code` = 31, whatever the code was before the shutdown.
- R10: A pulse width is the number of whole microseconds it spans. One microsecond is `CYC_PER_US` clocks, so a pulse of exactly N·`CYC_PER_US` clocks measures N µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_line | input | 1 | Asynchronous single-wire control input |
| step_code | output | CODE_W (6) | Reference code for the DAC |
| drv_en | output | 1 | Regulator enable |
| pulse_err | output | 1 | One-clock strobe for a rejected pulse |

## Verification
Low pulses are driven at each window edge and one microsecond beyond it: 0, 1, 60, 61, 139, 140, 240, 241 and 559 µs. This separates inclusive from exclusive bounds and shows that a measured width is counted in whole microseconds. Trains of pulses that run past 63 and below 0 tell saturation apart from wraparound. A held-low line is sampled just before and just after the 560 µs point to show that the enable drops while the line is still low, and a re-enable after the code has moved shows the return to mid-scale. Two dips separated by a sub-microsecond high show that the high-time rule rejects only the second dip.

// File: rtl/swstep_pkg.sv
// Shared types for the single-wire step controller.
package swstep_pkg;

    // Verdict on a completed low pulse.
    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_UP   = 2'd1,
        PK_DOWN = 2'd2,
        PK_BAD  = 2'd3
    } pulse_kind_t;

    // Regulator run state.
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } run_state_t;

endpackage

// File: rtl/swstep_sync.sv
// Multi-stage synchroniser for the asynchronous control wire.
// Assumes STAGES >= 2. The output resets to low.
module swstep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], din};
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/swstep_dwell.sv
// Measures how long the synchronised line has held its current level,
// in whole microseconds. A microsecond is CYC_PER_US clocks. The count
// restarts on every edge (the edge cycle counts as the first cycle of
// the new level) and saturates at SAT_US. Output dur_us at cycle t
// covers the run of level_prev up to cycle t-1.
module swstep_dwell #(
    parameter int CYC_PER_US = 50,
    parameter int SAT_US     = 560,
    parameter int US_W       = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            level_now,
    input  logic            level_prev,
    output logic [US_W-1:0] dur_us
);
    localparam int              PRE_W    = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
    localparam logic [US_W-1:0]  SAT_T    = US_W'(SAT_US);

    logic [PRE_W-1:0] pre_q, pre_d, pre_base;
    logic [US_W-1:0]  dur_q, dur_d, dur_base;
    logic             lvl_edge;

    // Pick the start point (restart on edge) and advance by one clock.
    always_comb begin
        lvl_edge = level_now ^ level_prev;
        pre_base = lvl_edge ? '0 : pre_q;
        dur_base = lvl_edge ? '0 : dur_q;
        if (pre_base == PRE_LAST) begin
            pre_d = '0;
            dur_d = (dur_base >= SAT_T) ? SAT_T : dur_base + US_W'(1);
        end else begin
            pre_d = pre_base + PRE_W'(1);
            dur_d = dur_base;
        end
    end

    // Hold the prescaler and microsecond count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            dur_q <= '0;
        end else begin
            pre_q <= pre_d;
            dur_q <= dur_d;
        end
    end

    assign dur_us = dur_q;

    // R10
    dur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dur_q <= SAT_T);

    // R10
    dur_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_now != level_prev) |=> (dur_q <= US_W'(1)));
endmodule

// File: rtl/swstep_judge.sv
// Classifies a finished low pulse from its width in microseconds and
// from whether enough high time preceded it. Purely combinational.
module swstep_judge
    import swstep_pkg::*;
#(
    parameter int US_W      = 10,
    parameter int UP_MIN_US = 1,
    parameter int UP_MAX_US = 60,
    parameter int DN_MIN_US = 140,
    parameter int DN_MAX_US = 240
) (
    input  logic [US_W-1:0] width_us,
    input  logic            gap_ok,
    output pulse_kind_t     kind
);
    localparam logic [US_W-1:0] UP_LO = US_W'(UP_MIN_US);
    localparam logic [US_W-1:0] UP_HI = US_W'(UP_MAX_US);
    localparam logic [US_W-1:0] DN_LO = US_W'(DN_MIN_US);
    localparam logic [US_W-1:0] DN_HI = US_W'(DN_MAX_US);

    // Map the width onto increment, decrement or reject.
    always_comb begin
        if (!gap_ok)
            kind = PK_BAD;
        else if (width_us >= UP_LO && width_us <= UP_HI)
            kind = PK_UP;
        else if (width_us >= DN_LO && width_us <= DN_HI)
            kind = PK_DOWN;
        else
            kind = PK_BAD;
    end
endmodule

// File: rtl/swstep_core.sv
// Run-state and code register. It enables on a high line while shut
// down, steps or rejects on each rising edge, and shuts down once the
// low time reaches OFF_US. Inputs are the synchronised line, its
// one-cycle-delayed copy and the dwell count of the delayed level.
module swstep_core
    import swstep_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int US_W        = 10,
    parameter int OFF_US      = 560,
    parameter int HIGH_MIN_US = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_now,
    input  logic              line_prev,
    input  logic [US_W-1:0]   dur_us,
    input  pulse_kind_t       kind,
    output logic              gap_ok,
    output logic [CODE_W-1:0] code,
    output logic              en,
    output logic              err
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'((1 << (CODE_W - 1)) - 1);
    localparam logic [US_W-1:0]   OFF_T    = US_W'(OFF_US);
    localparam logic [US_W-1:0]   HIGH_T   = US_W'(HIGH_MIN_US);

    run_state_t        state_q;
    logic [CODE_W-1:0] code_q;
    logic              err_q;
    logic              gap_ok_q;
    logic              rise, fall;

    assign rise = line_now & ~line_prev;
    assign fall = ~line_now & line_prev;

    // Advance the run state, the code and the error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            code_q   <= CODE_MID;
            err_q    <= 1'b0;
            gap_ok_q <= 1'b1;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_OFF: begin
                    if (line_now) begin
                        state_q  <= ST_ON;
                        code_q   <= CODE_MID;
                        gap_ok_q <= 1'b1;
                    end
                end
                default: begin
                    if (!line_prev && dur_us >= OFF_T) begin
                        state_q <= ST_OFF;
                        code_q  <= CODE_MID;
                    end else if (fall) begin
                        gap_ok_q <= (dur_us >= HIGH_T);
                    end else if (rise) begin
                        case (kind)
                            PK_UP:   if (code_q != CODE_MAX) code_q <= code_q + CODE_W'(1);
                            PK_DOWN: if (code_q != '0)       code_q <= code_q - CODE_W'(1);
                            PK_BAD:  err_q <= 1'b1;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    assign code   = code_q;
    assign en     = (state_q == ST_ON);
    assign err    = err_q;
    assign gap_ok = gap_ok_q;

    // R5
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    // R3 R4
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON) |=> (state_q == ST_OFF || code_q == $past(code_q)
            || code_q == $past(code_q) + CODE_W'(1)
            || code_q == $past(code_q) - CODE_W'(1)));

    // R6
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_MAX) |=> (code_q != '0));

    // R6
    no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0) |=> (code_q != CODE_MAX));

    // R7
    off_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == ST_ON) |-> $past(line_prev == 1'b0));

    // R9
    off_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (code_q == CODE_MID));

    // R2
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && line_now) |=> (state_q == ST_ON && code_q == CODE_MID));
endmodule

// File: rtl/swstep_ctrl.sv
// Top of the single-wire step controller: synchroniser, dwell timer,
// pulse judge and core. Assumes ctrl_line is asynchronous to clk and
// that CYC_PER_US clocks make one microsecond.
module swstep_ctrl
    import swstep_pkg::*;
#(
    parameter int CYC_PER_US  = 50,
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int UP_MIN_US   = 1,
    parameter int UP_MAX_US   = 60,
    parameter int DN_MIN_US   = 140,
    parameter int DN_MAX_US   = 240,
    parameter int OFF_US      = 560,
    parameter int HIGH_MIN_US = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_line,
    output logic [CODE_W-1:0] step_code,
    output logic              drv_en,
    output logic              pulse_err
);
    localparam int US_W = $clog2(OFF_US + 1);

    logic            line_s;
    logic            line_d;
    logic [US_W-1:0] dur_us;
    logic            gap_ok;
    pulse_kind_t     kind;

    swstep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ctrl_line),
        .dout (line_s)
    );

    // Delay the synchronised line by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_d <= 1'b0;
        else        line_d <= line_s;
    end

    swstep_dwell #(
        .CYC_PER_US(CYC_PER_US),
        .SAT_US    (OFF_US),
        .US_W      (US_W)
    ) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_now (line_s),
        .level_prev(line_d),
        .dur_us    (dur_us)
    );

    swstep_judge #(
        .US_W     (US_W),
        .UP_MIN_US(UP_MIN_US),
        .UP_MAX_US(UP_MAX_US),
        .DN_MIN_US(DN_MIN_US),
        .DN_MAX_US(DN_MAX_US)
    ) u_judge (
        .width_us(dur_us),
        .gap_ok  (gap_ok),
        .kind    (kind)
    );

    swstep_core #(
        .CODE_W     (CODE_W),
        .US_W       (US_W),
        .OFF_US     (OFF_US),
        .HIGH_MIN_US(HIGH_MIN_US)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_now (line_s),
        .line_prev(line_d),
        .dur_us   (dur_us),
        .kind     (kind),
        .gap_ok   (gap_ok),
        .code     (step_code),
        .en       (drv_en),
        .err      (pulse_err)
    );
endmodule

// File: tb/swstep_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for swstep_ctrl. A microsecond is shortened to
// DIV clocks to keep the run short.
module swstep_ctrl_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl = 1'b1;
    logic [5:0] code;
    logic       en;
    logic       perr;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;

    always #10 clk = ~clk;

    swstep_ctrl #(.CYC_PER_US(DIV)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_line(ctrl),
        .step_code(code),
        .drv_en   (en),
        .pulse_err(perr)
    );

    // Count error strobes, sampled away from the active edge.
    always @(negedge clk) if (rst_n && perr) err_seen++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive the line low for n clocks, then high for hi clocks.
    task automatic low_pulse(input int n, input int hi);
        @(negedge clk);
        ctrl = 1'b0;
        repeat (n) @(negedge clk);
        ctrl = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    // One pulse of us microseconds, then check the code and strobe count.
    task automatic step_case(input int us, input int exp_code, input int exp_errs, input string req);
        int e0;
        e0 = err_seen;
        low_pulse(us * DIV, 20);
        chk(code == exp_code, req, code, exp_code);
        chk(err_seen - e0 == exp_errs, {req, " strobe"}, err_seen - e0, exp_errs);
        chk(en == 1'b1, {req, " enable"}, en, 1);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(en == 1'b0, "R1 enable", en, 0);
        chk(code == 6'd31, "R1 code", code, 31);
        chk(perr == 1'b0, "R1 strobe", perr, 0);
    endtask

    task automatic t_enable();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(en == 1'b1, "R2 enable", en, 1);
        chk(code == 6'd31, "R2 code", code, 31);
    endtask

    task automatic t_up();
        step_case(1, 32, 0, "R3 1us");
        step_case(60, 33, 0, "R3 60us R10");
        step_case(61, 33, 1, "R5 61us");
        // Under 1 us: three clocks.
        begin
            int e0;
            e0 = err_seen;
            low_pulse(DIV - 1, 20);
            chk(code == 6'd33, "R5 sub-us code", code, 33);
            chk(err_seen - e0 == 1, "R5 sub-us strobe", err_seen - e0, 1);
        end
    endtask

    task automatic t_down();
        step_case(140, 32, 0, "R4 140us");
        step_case(240, 31, 0, "R4 240us");
        step_case(139, 31, 1, "R5 139us");
        step_case(241, 31, 1, "R5 241us");
        step_case(559, 31, 1, "R5 559us");
    endtask

    task automatic t_short_high();
        int e0;
        e0 = err_seen;
        low_pulse(2 * DIV, 2);
        low_pulse(2 * DIV, 20);
        chk(code == 6'd32, "R8 code", code, 32);
        chk(err_seen - e0 == 1, "R8 strobe", err_seen - e0, 1);
    endtask

    // Hold the line low past the threshold, then release it.
    task automatic shut_and_wake(input string req);
        int e0;
        e0 = err_seen;
        @(negedge clk);
        ctrl = 1'b0;
        repeat (560 * DIV - 10) @(negedge clk);
        chk(en == 1'b1, {req, " R7 before threshold"}, en, 1);
        repeat (30) @(negedge clk);
        chk(en == 1'b0, {req, " R7 dropped while low"}, en, 0);
        chk(code == 6'd31, {req, " R7 code"}, code, 31);
        ctrl = 1'b1;
        repeat (8) @(negedge clk);
        chk(en == 1'b1, {req, " R9 re-enable"}, en, 1);
        chk(code == 6'd31, {req, " R9 code"}, code, 31);
        chk(err_seen == e0, {req, " R7 no strobe"}, err_seen - e0, 0);
    endtask

    task automatic t_shutdown();
        low_pulse(2 * DIV, 20);
        chk(code == 6'd33, "R3 pre-shutdown", code, 33);
        shut_and_wake("shutdown");
    endtask

    task automatic t_saturate();
        int e0;
        for (int i = 0; i < 32; i++) low_pulse(2 * DIV, 20);
        chk(code == 6'd63, "R6 reach top", code, 63);
        e0 = err_seen;
        low_pulse(2 * DIV, 20);
        chk(code == 6'd63, "R6 hold top", code, 63);
        chk(err_seen == e0, "R6 top strobe", err_seen - e0, 0);
        shut_and_wake("from top");
        for (int i = 0; i < 31; i++) low_pulse(140 * DIV, 20);
        chk(code == 6'd0, "R6 reach bottom", code, 0);
        e0 = err_seen;
        low_pulse(140 * DIV, 20);
        chk(code == 6'd0, "R6 hold bottom", code, 0);
        chk(err_seen == e0, "R6 bottom strobe", err_seen - e0, 0);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_up();
        t_down();
        t_short_high();
        t_shutdown();
        t_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule